// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an interrupt router. A bus master does not address the routing registers directly. It first writes a register number into a select register at one bus offset. It then reads or writes the chosen register through a data window at a second offset. Behind the window are an identification register, a read-only version register, an arbitration register that always reads as zero, and a table of 64-bit per-pin routing entries. Each entry is reached as two 32-bit halves, through two adjacent register numbers.

Each accepted write to a table half raises a one-cycle rescan strobe on the cycle that follows. A separate delivery engine uses it to re-examine pending interrupts, and it reads whole 64-bit entries through a dedicated combinational port. Bus read data is combinational from the bus address and the current select value. The single-cycle write strobe is sampled on the rising clock edge.

Top module: `irq_route_regs`

## Requirements
- R1: A write at bus offset 0x00 (low 8 address bits) stores bus_wdata[7:0] as the select value. A read at offset 0x00 returns that value zero-extended to 32 bits.
- R2: At any offset other than 0x00 and 0x10, reads return zero and writes change neither the select value nor any register behind the window.
- R3: Select 0x00 is the identity register. A window write stores only wdata[27:24]. A window read returns those 4 bits in positions 27:24, with zero elsewhere.
- R4: Select 0x01 reads 0x11 in bits 7:0 and (NUM_PINS-1) in bits 23:16, with zero elsewhere (0x00170011 for 24 pins). Writes to it have no effect.
- R5: Select 0x02 always reads zero and ignores writes.
- R6: A select of 0x10 or above addresses table entry (select-0x10)/2. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. A write changes only that half.
- R7: A table select whose entry number is NUM_PINS or more reads zero. Writes to it change no entry and raise no rescan.
- R8: After reset the select value and the identity are zero. Every table entry holds 0x00000000_00010000, meaning only bit 16 (the mask bit) is set.
- R9: The rescan output is high for exactly the one cycle after each write that lands in a table half. It stays low after any other write.
- R10: The engine port returns the full 64-bit entry selected by eng_idx combinationally, and zero for an index of NUM_PINS or more.
- R11: Selects 0x03 through 0x0F read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus byte address; the low 8 bits are decoded |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| eng_idx | input | $clog2(NUM_PINS) | Entry index for the delivery engine |
| eng_entry | output | 64 | Full routing entry at eng_idx |
| rescan_o | output | 1 | One-cycle pulse after a table write |

## Verification
The bench builds the block with the default of 24 pins and an 8-bit address. With these values the version field reads 0x17, and select 0x40 is the first select past the table, so the out-of-range boundary sits just above entry 23's high half at 0x3F. The bench also checks that writes to select 0x40 and to the top select 0xFF do not alias onto entries 0 or 23 through truncated index bits. Half-isolation is checked by rewriting a low half after its high half has been written.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 8;

  // Bus offsets (low 8 address bits)
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  // Register numbers behind the window
  localparam logic [SEL_W-1:0] RSEL_ID   = 8'h00;
  localparam logic [SEL_W-1:0] RSEL_VER  = 8'h01;
  localparam logic [SEL_W-1:0] RSEL_ARB  = 8'h02;
  localparam logic [SEL_W-1:0] RSEL_TBL0 = 8'h10;

  localparam logic [7:0] VER_CODE = 8'h11;
  localparam int unsigned MASK_BIT = 16;
  localparam logic [DATA_W-1:0] ENTRY_LO_RST = DATA_W'(1) << MASK_BIT;
  localparam logic [DATA_W-1:0] ENTRY_HI_RST = '0;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_LO,
    TGT_HI
  } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [SEL_W-1:0] sel,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx
);
  localparam int RAW_W = SEL_W - 1;

  logic [SEL_W-1:0] tbl_off;
  logic [RAW_W-1:0] raw_idx;
  logic             in_tbl;

  always_comb begin
    tbl_off = sel - RSEL_TBL0;
    raw_idx = tbl_off[SEL_W-1:1];
    in_tbl  = (sel >= RSEL_TBL0) && ({{(32-RAW_W){1'b0}}, raw_idx} < 32'(NUM_PINS));
    idx     = raw_idx[IDX_W-1:0];
    if (sel == RSEL_ID)       tgt = TGT_ID;
    else if (sel == RSEL_VER) tgt = TGT_VER;
    else if (sel == RSEL_ARB) tgt = TGT_ARB;
    else if (in_tbl)          tgt = tbl_off[0] ? TGT_HI : TGT_LO;
    else                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/irq_route_ident.sv
module irq_route_ident
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_we,
  input  logic [3:0]        id_wval,
  output logic [DATA_W-1:0] id_word,
  output logic [DATA_W-1:0] ver_word
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  logic [3:0] id_q;

  always_ff @(posedge clk) begin
    if (rst)        id_q <= '0;
    else if (id_we) id_q <= id_wval;
  end

  assign id_word  = {4'd0, id_q, 24'd0};
  assign ver_word = {8'd0, MAX_PIN, 8'd0, VER_CODE};

  // R3
  id_keep_chk: assert property (@(posedge clk) disable iff (rst)
    id_we |=> id_word[27:24] == $past(id_wval));
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_word,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [2*DATA_W-1:0] eng_entry,
  output logic              rescan_o
);
  logic [DATA_W-1:0] lo_mem [NUM_PINS];
  logic [DATA_W-1:0] hi_mem [NUM_PINS];
  logic              rescan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        lo_mem[i] <= ENTRY_LO_RST;
        hi_mem[i] <= ENTRY_HI_RST;
      end
    end else begin
      if (wr_lo) lo_mem[wr_idx] <= wdata;
      if (wr_hi) hi_mem[wr_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rescan_q <= 1'b0;
    else     rescan_q <= wr_lo | wr_hi;
  end
  assign rescan_o = rescan_q;

  always_comb begin
    rd_word = '0;
    if (32'(rd_idx) < 32'(NUM_PINS))
      rd_word = rd_hi ? hi_mem[rd_idx] : lo_mem[rd_idx];
  end

  always_comb begin
    eng_entry = '0;
    if (32'(eng_idx) < 32'(NUM_PINS))
      eng_entry = {hi_mem[eng_idx], lo_mem[eng_idx]};
  end

  // R6
  one_half_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_lo, wr_hi}));

  // R7
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lo || wr_hi) |-> (32'(wr_idx) < 32'(NUM_PINS)));
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [$clog2(NUM_PINS)-1:0] eng_idx,
  output logic [63:0]                 eng_entry,
  output logic                        rescan_o
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        ofs;
  logic              at_sel, at_win;
  tgt_e              tgt;
  logic [IDX_W-1:0]  tidx;
  logic [DATA_W-1:0] id_word, ver_word, tbl_word;
  logic              wr_lo, wr_hi, id_we;

  assign ofs    = bus_addr[7:0];
  assign at_sel = (ofs == OFS_SEL);
  assign at_win = (ofs == OFS_WIN);

  always_ff @(posedge clk) begin
    if (rst)                  sel_q <= '0;
    else if (bus_wr && at_sel) sel_q <= bus_wdata[SEL_W-1:0];
  end

  irq_route_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .sel (sel_q),
    .tgt (tgt),
    .idx (tidx)
  );

  assign id_we = bus_wr && at_win && (tgt == TGT_ID);
  assign wr_lo = bus_wr && at_win && (tgt == TGT_LO);
  assign wr_hi = bus_wr && at_win && (tgt == TGT_HI);

  irq_route_ident #(.NUM_PINS(NUM_PINS)) u_ident (
    .clk      (clk),
    .rst      (rst),
    .id_we    (id_we),
    .id_wval  (bus_wdata[27:24]),
    .id_word  (id_word),
    .ver_word (ver_word)
  );

  irq_route_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_idx    (tidx),
    .wdata     (bus_wdata),
    .rd_idx    (tidx),
    .rd_hi     (tgt == TGT_HI),
    .rd_word   (tbl_word),
    .eng_idx   (eng_idx),
    .eng_entry (eng_entry),
    .rescan_o  (rescan_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (at_sel) bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
    else if (at_win) begin
      unique case (tgt)
        TGT_ID:        bus_rdata = id_word;
        TGT_VER:       bus_rdata = ver_word;
        TGT_LO, TGT_HI: bus_rdata = tbl_word;
        default:       bus_rdata = '0;
      endcase
    end
  end

  // R1
  sel_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_sel) |=> (!at_sel || bus_rdata == {24'd0, $past(bus_wdata[7:0])}));

  // R2
  other_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (!at_sel && !at_win) |-> bus_rdata == '0);

  // R4
  ver_read_chk: assert property (@(posedge clk) disable iff (rst)
    (at_win && sel_q == RSEL_VER) |-> bus_rdata == {8'd0, 8'(NUM_PINS-1), 8'd0, VER_CODE});

  // R9
  rescan_src_chk: assert property (@(posedge clk) disable iff (rst)
    rescan_o |-> $past(bus_wr && at_win && sel_q >= RSEL_TBL0));
endmodule

// File: tb/test_irq_route_regs.sv
`timescale 1ns/1ps
module test_irq_route_regs;
  localparam int NPINS = 24;
  localparam int IW = $clog2(NPINS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [IW-1:0] eng_idx = '0;
  logic [63:0]   eng_entry;
  logic          rescan_o;

  int checks = 0;
  int errors = 0;
  logic last_rescan;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  event        smp_ev;

  always #4 clk = ~clk;

  irq_route_regs #(.NUM_PINS(NPINS), .ADDR_W(8)) i_irq_route_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_idx(eng_idx),
    .eng_entry(eng_entry), .rescan_o(rescan_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() != 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {32'd0, bus_rdata}, {32'd0, e});
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    last_rescan = rescan_o;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    #1 ->smp_ev;
    #1;
  endtask

  task automatic win_read(input logic [7:0] s, input logic [31:0] e, input string t);
    bus_write(8'h00, {24'd0, s});
    bus_read(8'h10, e, t);
  endtask

  task automatic eng_check(input int i, input logic [63:0] e, input string t);
    @(negedge clk);
    eng_idx = IW'(i);
    #1 check(t, eng_entry, e);
  endtask

  localparam logic [63:0] ERST = 64'h0000_0000_0001_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    bus_read(8'h00, 32'h0, "R8 select after reset");
    bus_read(8'h10, 32'h0, "R8 identity after reset");
    for (int i = 0; i < NPINS; i++) eng_check(i, ERST, "R8 entry reset value");
    win_read(8'h3E, 32'h0001_0000, "R8 entry23 low via window");
    win_read(8'h3F, 32'h0, "R8 entry23 high via window");

    // R1 select echo
    bus_write(8'h00, 32'h0000_00A5);
    bus_read(8'h00, 32'h0000_00A5, "R1 select readback");
    bus_write(8'h00, 32'h1234_56C3);
    bus_read(8'h00, 32'h0000_00C3, "R1 select keeps low byte");

    // R3 identity
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    check("R9 no rescan on identity write", {63'd0, last_rescan}, 64'd0);
    bus_read(8'h10, 32'h0F00_0000, "R3 identity keeps 27:24");
    bus_write(8'h10, 32'h0500_0000);
    bus_read(8'h10, 32'h0500_0000, "R3 identity value 5");

    // R4 version
    win_read(8'h01, 32'h0017_0011, "R4 version word");
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h0017_0011, "R4 version ignores write");

    // R5 arbitration
    win_read(8'h02, 32'h0, "R5 arbitration reads zero");
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h0, "R5 arbitration ignores write");

    // R11 gap selects
    win_read(8'h07, 32'h0, "R11 gap select reads zero");
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h0, "R11 gap select ignores write");
    win_read(8'h0F, 32'h0, "R11 select 0x0F reads zero");
    win_read(8'h00, 32'h0500_0000, "R11 identity untouched by gap write");

    // R6 / R9 table halves
    bus_write(8'h00, 32'h1A);
    bus_write(8'h10, 32'hDEAD_BEEF);
    check("R9 rescan after low write", {63'd0, last_rescan}, 64'd1);
    @(negedge clk);
    check("R9 rescan one cycle wide", {63'd0, rescan_o}, 64'd0);
    bus_write(8'h00, 32'h1B);
    bus_write(8'h10, 32'h1234_5678);
    check("R9 rescan after high write", {63'd0, last_rescan}, 64'd1);
    bus_read(8'h10, 32'h1234_5678, "R6 odd select high half");
    win_read(8'h1A, 32'hDEAD_BEEF, "R6 even select low half");
    eng_check(5, 64'h1234_5678_DEAD_BEEF, "R10 engine full entry 5");
    eng_check(4, ERST, "R6 neighbour entry 4 untouched");
    eng_check(6, ERST, "R6 neighbour entry 6 untouched");
    bus_write(8'h10, 32'h0000_00AA);
    eng_check(5, 64'h1234_5678_0000_00AA, "R6 low write keeps high half");

    // R2 other offsets
    bus_read(8'h04, 32'h0, "R2 offset 0x04 reads zero");
    bus_write(8'h14, 32'hFFFF_FFFF);
    check("R9 no rescan on other offset", {63'd0, last_rescan}, 64'd0);
    bus_write(8'h04, 32'h0000_0003);
    bus_read(8'h00, 32'h0000_001A, "R2 select untouched by other offset");
    bus_read(8'h10, 32'h0000_00AA, "R2 entry untouched by other offset");

    // R7 past the table
    win_read(8'h40, 32'h0, "R7 select 0x40 reads zero");
    bus_write(8'h10, 32'hFFFF_FFFF);
    check("R7 no rescan past table", {63'd0, last_rescan}, 64'd0);
    bus_read(8'h10, 32'h0, "R7 select 0x40 ignores write");
    win_read(8'hFF, 32'h0, "R7 select 0xFF reads zero");
    bus_write(8'h10, 32'hFFFF_FFFF);
    eng_check(0, ERST, "R7 entry 0 not aliased");
    eng_check(23, ERST, "R7 entry 23 not aliased");
    eng_check(31, 64'd0, "R10 engine index past table");

    @(negedge clk);
    #1 check("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule